// File: doc/BRIEF.md
# Cascaded 32-Line Interrupt Controller

This block gathers up to 32 maskable interrupt request lines into one parent interrupt that goes to the processor. Each line keeps a level bit and an enable flag. The level bit is set when the line's request input rises and is cleared when that input falls. A line is pending when its level is 1 and its enable flag is 1. The parent output stays high while at least one line is pending.

Software uses a 32-bit register bus with five word offsets. Two of them are read-only: one returns the number of pending lines and the other returns the index of the lowest-numbered pending line. The other three are write-only commands. One clears the level bit of every line and leaves every enable flag as it was. The other two set or clear the enable flag of the single line whose index is written. A read strobe loads the read data register on the next clock edge. The value stays on the bus until the next read.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset, every level bit and every enable flag is 0. The parent output is low, and both read registers return 0.
- R2: A line's level bit becomes 1 on the clock edge after its request input goes from 0 to 1. It becomes 0 on the clock edge after that input goes from 1 to 0.
- R3: A line is pending only when its level bit and its enable flag are both 1. A raised line that is disabled does not count in the pending count and does not raise the parent output.
- R4: A read of offset 0x00 returns the number of pending lines, from 0 to 32, in the low bits of the read data. All other bits are 0.
- R5: A read of offset 0x04 returns the index of the lowest-numbered pending line. It returns 0 when no line is pending.
- R6: A write of any value to offset 0x08 clears the level bit of every line, whether the line is enabled or disabled, and leaves all enable flags unchanged. A cleared level stays 0 while the request input is still high. It is set again only on a new rising edge of that input. If a line rises in the same cycle as the write, the rise takes priority.
- R7: A write to offset 0x10 sets the enable flag of the line whose index is the write data. A write to offset 0x0C clears that flag. No other line's flag changes.
- R8: Enabling a line whose level bit is already 1 makes the line pending at once. The parent output goes high on the clock edge that takes the write.
- R9: A write to offset 0x0C or 0x10 with a data value above 31 has no effect on any enable flag.
- R10: The read data register loads on the clock edge that takes a read strobe. Reads of offsets 0x08, 0x0C, 0x10 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 32 | Request inputs, one per line |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| parent_irq | output | 1 | Parent interrupt to the processor |

## Verification
Several properties are checked by assertions on every cycle. The parent output matches a non-zero pending count. The reported lowest index always points at a pending line. The count never goes above the number of lines. A clear-all leaves the enable flags as they were and leaves no level set except where a rise arrived in that cycle. An enable or disable command changes at most one flag, and a command with an index out of range changes none. Other behaviour is shown only by the bench scenarios. This covers the exact count and lowest-index values for particular patterns, and the level staying low under a request that is still held high after a clear-all. It also covers the one-cycle read latency and the zero value returned from write-only and unmapped offsets.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LINES  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFF_COUNT  = 5'h00,
        OFF_LOWEST = 5'h04,
        OFF_CLRALL = 5'h08,
        OFF_MASK   = 5'h0C,
        OFF_UNMASK = 5'h10
    } reg_off_e;

    typedef struct packed {
        logic clear_all;
        logic set_en;
        logic clr_en;
    } cmd_t;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_LINES = LINES,
    parameter int IDX_W   = $clog2(N_LINES),
    parameter int CNT_W   = $clog2(N_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  pend_count,
    input  logic [IDX_W-1:0]  pend_lowest,
    output cmd_t              cmd,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [DATA_W-1:0] bus_rdata
);

    logic idx_ok;
    logic [DATA_W-1:0] rd_mux;

    assign idx_ok  = (bus_wdata < DATA_W'(N_LINES));
    assign cmd_idx = bus_wdata[IDX_W-1:0];

    always_comb begin
        cmd           = '0;
        cmd.clear_all = bus_wr && (bus_addr == OFF_CLRALL);
        cmd.clr_en    = bus_wr && (bus_addr == OFF_MASK)   && idx_ok;
        cmd.set_en    = bus_wr && (bus_addr == OFF_UNMASK) && idx_ok;
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFF_COUNT:  rd_mux = DATA_W'(pend_count);
            OFF_LOWEST: rd_mux = DATA_W'(pend_lowest);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // R9: out-of-range index never produces a command
    p_range_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_wdata >= DATA_W'(N_LINES))) |-> !(cmd.set_en || cmd.clr_en));

    // R10: write-only and unmapped offsets read back zero
    p_wo_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr != OFF_COUNT) && (bus_addr != OFF_LOWEST)) |=> (bus_rdata == '0));

endmodule

// File: rtl/irqc_line_bank.sv
module irqc_line_bank
    import irqc_pkg::*;
#(
    parameter int N_LINES = LINES,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] req_in,
    input  cmd_t               cmd,
    input  logic [IDX_W-1:0]   cmd_idx,
    output logic [N_LINES-1:0] pend
);

    logic [N_LINES-1:0] req_q;
    logic [N_LINES-1:0] level;
    logic [N_LINES-1:0] enable;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] fall;

    assign rise = req_in & ~req_q;
    assign fall = ~req_in & req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= req_in;
        end
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic sel;
        assign sel = (cmd_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                level[i] <= 1'b0;
            end else if (rise[i]) begin
                level[i] <= 1'b1;
            end else if (fall[i] || cmd.clear_all) begin
                level[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                enable[i] <= 1'b0;
            end else if (cmd.set_en && sel) begin
                enable[i] <= 1'b1;
            end else if (cmd.clr_en && sel) begin
                enable[i] <= 1'b0;
            end
        end
    end

    assign pend = level & enable;

    // R6: clear-all keeps every enable flag
    p_keep_en_r6: assert property (@(posedge clk) disable iff (rst)
        cmd.clear_all |=> $stable(enable));

    // R6: after clear-all only lines that rose in that cycle keep a level
    p_clear_lvl_r6: assert property (@(posedge clk) disable iff (rst)
        cmd.clear_all |=> ((level & ~$past(rise)) == '0));

    // R7: one command touches at most one enable flag
    p_single_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(enable ^ $past(enable)) <= 1));

    // R8: enabling a raised line makes it pending at once
    p_unmask_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd.set_en && level[cmd_idx] && req_in[cmd_idx] && !cmd.clear_all)
        |=> pend[$past(cmd_idx)]);

    // R2: a falling request leaves its level low
    p_fall_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((level & $past(fall)) == '0));

endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
    import irqc_pkg::*;
#(
    parameter int N_LINES = LINES,
    parameter int IDX_W   = $clog2(N_LINES),
    parameter int CNT_W   = $clog2(N_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] pend,
    output logic [CNT_W-1:0]   pend_count,
    output logic [IDX_W-1:0]   pend_lowest,
    output logic               any_pend
);

    always_comb begin
        pend_count = '0;
        for (int i = 0; i < N_LINES; i++) begin
            pend_count = pend_count + CNT_W'(pend[i]);
        end
    end

    always_comb begin
        pend_lowest = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pend_lowest = IDX_W'(i);
            end
        end
    end

    assign any_pend = |pend;

    // R3: parent output agrees with a non-zero pending count
    p_parent_r3: assert property (@(posedge clk) disable iff (rst)
        any_pend == (pend_count != '0));

    // R4: count bounded by the number of lines
    p_count_r4: assert property (@(posedge clk) disable iff (rst)
        pend_count <= CNT_W'(N_LINES));

    // R5: reported lowest index is a pending line with nothing below it
    p_lowest_r5: assert property (@(posedge clk) disable iff (rst)
        any_pend |-> (pend[pend_lowest] &&
                      ((pend & ((N_LINES'(1) << pend_lowest) - N_LINES'(1))) == '0)));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_LINES = LINES,
    parameter int IDX_W   = $clog2(N_LINES),
    parameter int CNT_W   = $clog2(N_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] req_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               parent_irq
);

    cmd_t               cmd;
    logic [IDX_W-1:0]   cmd_idx;
    logic [N_LINES-1:0] pend;
    logic [CNT_W-1:0]   pend_count;
    logic [IDX_W-1:0]   pend_lowest;

    irqc_regs #(.N_LINES(N_LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .pend_count  (pend_count),
        .pend_lowest (pend_lowest),
        .cmd         (cmd),
        .cmd_idx     (cmd_idx),
        .bus_rdata   (bus_rdata)
    );

    irqc_line_bank #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req_in  (req_in),
        .cmd     (cmd),
        .cmd_idx (cmd_idx),
        .pend    (pend)
    );

    irqc_summary #(.N_LINES(N_LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_sum (
        .clk         (clk),
        .rst         (rst),
        .pend        (pend),
        .pend_count  (pend_count),
        .pend_lowest (pend_lowest),
        .any_pend    (parent_irq)
    );

    // R1: nothing pending in the first cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> !parent_irq);

endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        parent_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    irqc_top uut (
        .clk        (clk),
        .rst        (rst),
        .req_in     (req_in),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .parent_irq (parent_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_req(logic [31:0] v);
        req_in = v;
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 parent", {31'b0, parent_irq}, 32'd0);
        rd(5'h00, d); check("R1 count", d, 32'd0);
        rd(5'h04, d); check("R1 lowest", d, 32'd0);
    endtask

    task automatic t_mask_unmask();
        logic [31:0] d;
        set_req(32'h0000_0020);
        rd(5'h00, d); check("R3 masked count", d, 32'd0);
        check("R3 masked parent", {31'b0, parent_irq}, 32'd0);
        wr(5'h10, 32'd5);
        check("R8 parent after unmask", {31'b0, parent_irq}, 32'd1);
        rd(5'h00, d); check("R4 count one", d, 32'd1);
        rd(5'h04, d); check("R5 lowest five", d, 32'd5);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        wr(5'h10, 32'd3);
        wr(5'h10, 32'd31);
        set_req(32'h8000_0028);
        rd(5'h00, d); check("R4 count three", d, 32'd3);
        rd(5'h04, d); check("R5 lowest three", d, 32'd3);
        set_req(32'h8000_0020);
        rd(5'h00, d); check("R2 count after fall", d, 32'd2);
        rd(5'h04, d); check("R2 lowest after fall", d, 32'd5);
        wr(5'h0C, 32'd5);
        rd(5'h04, d); check("R7 lowest after mask", d, 32'd31);
        rd(5'h00, d); check("R7 count after mask", d, 32'd1);
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int i = 0; i < 32; i++) wr(5'h10, i);
        set_req(32'hFFFF_FFFF);
        rd(5'h00, d); check("R4 count full", d, 32'd32);
        rd(5'h04, d); check("R5 lowest zero", d, 32'd0);
        set_req(32'hFFFF_FFFE);
        rd(5'h04, d); check("R5 lowest one", d, 32'd1);
        rd(5'h00, d); check("R4 count 31", d, 32'd31);
    endtask

    task automatic t_clear_all();
        logic [31:0] d;
        wr(5'h0C, 32'd9);
        wr(5'h08, 32'h0);
        check("R6 parent after clear", {31'b0, parent_irq}, 32'd0);
        rd(5'h00, d); check("R6 count after clear", d, 32'd0);
        tick(3);
        rd(5'h00, d); check("R6 stays cleared", d, 32'd0);
        wr(5'h10, 32'd9);
        rd(5'h00, d); check("R6 disabled line cleared", d, 32'd0);
        set_req(32'hFFFF_FF7E);
        set_req(32'hFFFF_FFFE);
        rd(5'h00, d); check("R6 enables kept count", d, 32'd1);
        rd(5'h04, d); check("R6 enables kept lowest", d, 32'd7);
    endtask

    task automatic t_range();
        logic [31:0] d;
        wr(5'h08, 32'h0);
        set_req(32'h0);
        wr(5'h0C, 32'd2);
        set_req(32'h0000_0004);
        wr(5'h10, 32'd34);
        wr(5'h10, 32'h0000_0102);
        rd(5'h00, d); check("R9 enable out of range", d, 32'd0);
        check("R9 parent", {31'b0, parent_irq}, 32'd0);
        wr(5'h10, 32'd2);
        wr(5'h0C, 32'd32);
        wr(5'h0C, 32'hFFFF_FFE2);
        rd(5'h04, d); check("R9 disable out of range", d, 32'd2);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        rd(5'h00, d); check("R10 count before", d, 32'd1);
        rd(5'h08, d); check("R10 clear-all reads zero", d, 32'd0);
        rd(5'h10, d); check("R10 unmask reads zero", d, 32'd0);
        rd(5'h14, d); check("R10 unmapped zero", d, 32'd0);
        rd(5'h04, d);
        tick(2);
        check("R10 data held", bus_rdata, 32'd2);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_mask_unmask();
        t_levels();
        t_full();
        t_clear_all();
        t_range();
        t_readback();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule